// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Character Receiver

This block turns a serial line into parallel characters. The line rests high between characters. The receiver runs entirely on its system clock, and each clock period counts as one sample. One bit lasts either 16 or 64 samples, depending on a factor select input.

When enabled, the receiver watches for the line going low. It does not accept a start bit until it has looked at the line again half a bit later. After a start bit is accepted, it samples every following bit at its middle: first the data bits, least significant first, then an optional parity bit, then the stop bit.

The finished character is copied into a holding register for the host. Alongside it the block keeps four flags: ready, parity error, framing error and overrun. The host signals that it has taken the character with a one-cycle acknowledge pulse.

Top module: `serial_char_receiver`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rx_ready`, `overrun`, `parity_err`, `frame_err` and `rx_data` are all zero.
- R2: A low level on `rxd` is taken as a start bit only if the line is still low half a bit time later (8 or 64/2 samples). A low pulse shorter than that produces no character and leaves `rx_ready` low.
- R3: `char_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives least significant bit first. The character is right-aligned in `rx_data`, and the bits above its length read as zero.
- R4: `par_mode` 2'b01 selects odd parity and 2'b10 selects even parity. One parity bit follows the data bits. If the data and parity bits together do not have the selected ones-count parity, `parity_err` is set with the character. Codes 2'b00 and 2'b11 mean that no parity bit is expected, and `parity_err` stays low.
- R5: A stop bit sampled low sets `frame_err`, and the character is still delivered with `rx_ready`.
- R6: When `div_sel` is 0, a bit lasts 16 clocks. When it is 1, a bit lasts 64 clocks. Every bit after the start bit is sampled one full bit time after the previous sample.
- R7: While `rx_en` is low, no character is delivered, and any character in progress is abandoned.
- R8: `rx_ready` rises one cycle after a character completes. It stays high until `rd_ack` is pulsed, and it is low in the cycle after that pulse (unless another character completes in the same cycle).
- R9: If a character completes while `rx_ready` is still high and `rd_ack` is not asserted, `overrun` is set and `rx_data` takes the newer character. `rd_ack` clears `overrun`.
- R10: `rx_data` and the two error flags change only when a character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; each cycle is one sample |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Character length code (5 to 8 bits) |
| par_mode | input | 2 | Parity mode: 01 odd, 10 even, other codes none |
| div_sel | input | 1 | Samples per bit: 0 gives 16, 1 gives 64 |
| rd_ack | input | 1 | Host has read the holding register |
| rx_data | output | 8 | Last received character, right-aligned |
| rx_ready | output | 1 | Unread character available |
| parity_err | output | 1 | Parity mismatch on the last character |
| frame_err | output | 1 | Stop bit of the last character was low |
| overrun | output | 1 | A character was replaced before it was read |

## Verification
The hardest situation to reach from the ports is a start bit that fails its half-bit check. It needs a low pulse that is long enough to pass the input synchronizer, yet clears before the confirmation sample.

The bench drives a three-sample low pulse and then waits more than a full character time with the line high. This confirms that nothing is delivered. The bench then receives a normal frame, to show that the receiver went back to its idle state.

Overrun is reached by sending two frames back to back without an acknowledge.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP
  } rx_state_t;

  localparam logic [1:0] PM_ODD  = 2'b01;
  localparam logic [1:0] PM_EVEN = 2'b10;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line,
  input  logic [1:0]        len_code,
  input  logic [1:0]        par_code,
  input  logic              div_sel,
  output logic              done,
  output logic [DATA_W-1:0] char_q,
  output logic              perr_q,
  output logic              ferr_q
);
  localparam int CNT_W    = $clog2(SLOW_DIV);
  localparam int IDX_W    = $clog2(DATA_W + 1);
  localparam int LEN_BASE = DATA_W - 3;

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] shreg;
  logic             acc;

  logic [CNT_W-1:0] full_m1, half_m1;
  logic [IDX_W-1:0] nbits;
  logic             par_on, par_odd, full_hit, half_hit;

  assign full_m1  = div_sel ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
  assign half_m1  = div_sel ? CNT_W'(SLOW_DIV / 2 - 1) : CNT_W'(FAST_DIV / 2 - 1);
  assign nbits    = IDX_W'(LEN_BASE) + IDX_W'(len_code);
  assign par_on   = (par_code == PM_ODD) || (par_code == PM_EVEN);
  assign par_odd  = (par_code == PM_ODD);
  assign full_hit = (cnt == full_m1);
  assign half_hit = (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RS_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      acc    <= 1'b0;
      done   <= 1'b0;
      char_q <= '0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RS_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          RS_IDLE: begin
            cnt <= '0;
            if (!line) state <= RS_START;
          end
          RS_START: begin
            if (half_hit) begin
              cnt <= '0;
              idx <= '0;
              acc <= 1'b0;
              state <= line ? RS_IDLE : RS_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_DATA: begin
            if (full_hit) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_W-1:1]};
              acc   <= acc ^ line;
              idx   <= idx + 1'b1;
              if (idx == nbits - 1'b1) state <= par_on ? RS_PAR : RS_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_PAR: begin
            if (full_hit) begin
              cnt   <= '0;
              acc   <= acc ^ line;
              state <= RS_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_STOP: begin
            if (full_hit) begin
              cnt    <= '0;
              done   <= 1'b1;
              char_q <= shreg >> (DATA_W - int'(nbits));
              perr_q <= par_on && (acc ^ par_odd);
              ferr_q <= !line;
              state  <= RS_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] char_in,
  input  logic              perr_in,
  input  logic              ferr_in,
  input  logic              ack,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              perr_q,
  output logic              ferr_q,
  output logic              ovr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (load) begin
        data_q  <= char_in;
        perr_q  <= perr_in;
        ferr_q  <= ferr_in;
        ready_q <= 1'b1;
      end else if (ack) begin
        ready_q <= 1'b0;
      end
      if (ack)                ovr_q <= 1'b0;
      else if (load && ready_q) ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_char_receiver.sv
module serial_char_receiver #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FAST_DIV    = 16,
  parameter int SLOW_DIV    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              div_sel,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              parity_err,
  output logic              frame_err,
  output logic              overrun
);
  logic              line_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_char;
  logic              frame_perr, frame_ferr;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  srx_frame_fsm #(.DATA_W(DATA_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_fsm (
    .clk(clk), .rst(rst), .en(rx_en), .line(line_s),
    .len_code(char_len), .par_code(par_mode), .div_sel(div_sel),
    .done(frame_done), .char_q(frame_char), .perr_q(frame_perr), .ferr_q(frame_ferr)
  );

  srx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .load(frame_done), .char_in(frame_char),
    .perr_in(frame_perr), .ferr_in(frame_ferr), .ack(rd_ack),
    .data_q(rx_data), .ready_q(rx_ready), .perr_q(parity_err),
    .ferr_q(frame_err), .ovr_q(overrun)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic [1:0]        char_len,
  input logic              rd_ack,
  input logic              done,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              parity_err,
  input logic              frame_err,
  input logic              overrun
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!rx_ready && !overrun && !parity_err && !frame_err && rx_data == '0));

  assert_ready_set_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_ready);

  assert_ready_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !done) |=> !rx_ready);

  assert_overrun_R9: assert property (@(posedge clk) disable iff (rst)
    (done && rx_ready && !rd_ack) |=> overrun);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(rx_data) && $stable(parity_err) && $stable(frame_err)));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (done && char_len == 2'd0) |=> (rx_data[DATA_W-1:DATA_W-3] == '0));

  assert_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !done);
endmodule

bind serial_char_receiver srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .char_len(char_len), .rd_ack(rd_ack),
  .done(frame_done), .rx_data(rx_data), .rx_ready(rx_ready),
  .parity_err(parity_err), .frame_err(frame_err), .overrun(overrun)
);

// File: tb/serial_char_receiver_test.sv
`timescale 1ns/1ps
module serial_char_receiver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] char_len = 2'd3;
  logic [1:0] par_mode = 2'b00;
  logic       div_sel = 1'b0;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, parity_err, frame_err, overrun;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  serial_char_receiver uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rxd(rxd), .char_len(char_len),
    .par_mode(par_mode), .div_sel(div_sel), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_ready(rx_ready), .parity_err(parity_err), .frame_err(frame_err),
    .overrun(overrun)
  );

  // [15:14] len code, [13:12] parity code, [11] factor, [10] stop high,
  // [9] flip parity bit, [7:0] data
  localparam logic [15:0] VEC [8] = '{
    {2'd3, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5},
    {2'd0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF},
    {2'd1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h2C},
    {2'd2, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5B},
    {2'd3, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C},
    {2'd3, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81},
    {2'd3, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7E},
    {2'd3, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic [1:0] pm,
                            input int div, input logic stop_v, input logic flip);
    logic ones;
    ones = 1'b0;
    hold_line(1'b0, div);
    for (int i = 0; i < nb; i++) begin
      ones ^= d[i];
      hold_line(d[i], div);
    end
    if (pm == 2'b01) hold_line(~ones ^ flip, div);
    else if (pm == 2'b10) hold_line(ones ^ flip, div);
    hold_line(stop_v, div);
    hold_line(1'b1, div);
  endtask

  task automatic wait_ready(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (rx_ready) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic ack_pulse();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic seen;
    int nb, div;
    logic [7:0] expd;
    logic exp_perr;

    repeat (3) @(negedge clk);
    check("R1 ready", rx_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flags", {overrun, parity_err, frame_err, rx_ready}, 0);
    check("R1 data", rx_data, 0);
    rx_en = 1'b1;
    repeat (5) @(negedge clk);

    foreach (VEC[k]) begin
      char_len = VEC[k][15:14];
      par_mode = VEC[k][13:12];
      div_sel  = VEC[k][11];
      nb  = 5 + int'(VEC[k][15:14]);
      div = VEC[k][11] ? 64 : 16;
      expd = VEC[k][7:0] & 8'((1 << nb) - 1);
      exp_perr = (VEC[k][13:12] == 2'b01 || VEC[k][13:12] == 2'b10) && VEC[k][9];
      send_frame(VEC[k][7:0], nb, VEC[k][13:12], div, VEC[k][10], VEC[k][9]);
      wait_ready(seen);
      check("R8 ready after frame (R6 factor)", seen, 1);
      check("R3 data length and order", rx_data, expd);
      check("R4 parity flag", parity_err, exp_perr);
      check("R5 framing flag", frame_err, !VEC[k][10]);
      ack_pulse();
      check("R8 ready cleared by ack", rx_ready, 0);
      check("R10 data held after ack", rx_data, expd);
    end

    // R2: short glitch rejected
    char_len = 2'd3; par_mode = 2'b00; div_sel = 1'b0;
    hold_line(1'b0, 3);
    hold_line(1'b1, 300);
    check("R2 glitch gives no char", rx_ready, 0);
    send_frame(8'h96, 8, 2'b00, 16, 1'b1, 1'b0);
    wait_ready(seen);
    check("R2 frame after glitch", rx_data, 8'h96);
    ack_pulse();

    // R7: disabled receiver ignores frame
    rx_en = 1'b0;
    send_frame(8'h33, 8, 2'b00, 16, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    check("R7 no char while disabled", rx_ready, 0);
    check("R7 data unchanged", rx_data, 8'h96);
    // R7: disable mid-frame
    rx_en = 1'b1;
    repeat (5) @(negedge clk);
    hold_line(1'b0, 16);
    hold_line(1'b1, 40);
    rx_en = 1'b0;
    hold_line(1'b1, 200);
    check("R7 aborted frame not delivered", rx_ready, 0);
    rx_en = 1'b1;
    repeat (5) @(negedge clk);

    // R9: overrun
    send_frame(8'h11, 8, 2'b00, 16, 1'b1, 1'b0);
    send_frame(8'h22, 8, 2'b00, 16, 1'b1, 1'b0);
    check("R9 overrun set", overrun, 1);
    check("R9 newest data kept", rx_data, 8'h22);
    ack_pulse();
    check("R9 overrun cleared", overrun, 0);
    check("R8 ready cleared", rx_ready, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule